// File: doc/BRIEF.md
# Timer interrupt status register

This block keeps the interrupt state of a down-counting pulse timer. It holds three cause flags (trigger seen, duty value matched, counter wrapped below zero) and one enable bit for each. The timer sends one-cycle event pulses. Software writes a byte to clear flags and to set enables. It reads the same byte back.

A flag is set only by its event. Software can clear a flag by writing 0 to it. Writing 1 to a flag does nothing. During a read-modify-write access, the read path returns every flag as 1. This means a bit-set or bit-clear instruction on the enables writes 1 back to the flags, and so it cannot clear a pending cause by accident. The interrupt request is a registered OR of the flags that are enabled. It stays high until software clears the flags or the enables.

Top module: `tis_status`

## Requirements
- R1: After reset, every flag and enable is 0, `irq_o` is 0, and a normal read returns 0x00.
- R2: The byte layout is as follows. Bit 6 is the trigger enable, bit 5 the duty enable and bit 4 the underflow enable. Bit 2 is the trigger flag, bit 1 the duty flag and bit 0 the underflow flag. Bits 7 and 3 always read 0, whatever was written to them.
- R3: `evt_i` bit 2 (trigger), bit 1 (duty match) and bit 0 (underflow) each set the flag of the same bit index at the next clock edge.
- R4: A write with a 0 in a flag position clears that flag. A write with a 1 in a flag position leaves the flag unchanged.
- R5: If an event and a clearing write reach the same flag in the same cycle, the flag ends up 1.
- R6: While `rd_i` and `rmw_i` are both high, bits 2:0 of `rdata_o` read 1. Bits 6:4 still show the stored enables. The access changes no state.
- R7: Each write loads bits 6:4 of `wdata_i` into the three enables.
- R8: `irq_o` is 1 one cycle after a state in which some flag and its enable are both 1. It is 0 one cycle after a state with no such pair.
- R9: While `rd_i` is low, `rdata_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 3 | One-cycle event pulses: [2] trigger, [1] duty match, [0] underflow |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data byte |
| rd_i | input | 1 | Read strobe |
| rmw_i | input | 1 | Marks the read as part of a read-modify-write access |
| rdata_o | output | 8 | Read data byte (combinational, 0 when not reading) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A wrong flag shows at the read port in the cycle after the event or write that caused it. It also shows on `irq_o` one cycle after that, if its enable is set. A wrong enable shows up at once in bits 6:4 of a read. A bad read-modify-write override shows only while `rmw_i` is high, as flag bits that are not forced to 1. The sweep covers every combination of stored flags, flag bits in the write, and same-cycle events. After each case it checks both read forms and the request line.

// File: rtl/tis_pkg.sv
package tis_pkg;
  localparam int NUM_SRC  = 3;
  localparam int DATA_W   = 8;
  localparam int FLAG_LSB = 0;
  localparam int EN_LSB   = 4;
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/tis_flag_cell.sv
module tis_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q;

  // event has priority over a clearing write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              flag_q <= 1'b0;
    else if (set_i)           flag_q <= 1'b1;
    else if (wr_i && !wbit_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/tis_enable_reg.sv
module tis_enable_reg #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (wr_i) en_q <= wdata_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/tis_read_mux.sv
module tis_read_mux #(
  parameter int N        = 3,
  parameter int DW       = 8,
  parameter int FLAG_LSB = 0,
  parameter int EN_LSB   = 4
) (
  input  logic          rd_i,
  input  logic          rmw_i,
  input  logic [N-1:0]  flag_i,
  input  logic [N-1:0]  en_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] word;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (b >= FLAG_LSB && b < FLAG_LSB + N) begin : g_flag
      // read-modify-write returns 1 so write-back never clears a cause
      assign word[b] = rmw_i | flag_i[b-FLAG_LSB];
    end else if (b >= EN_LSB && b < EN_LSB + N) begin : g_en
      assign word[b] = en_i[b-EN_LSB];
    end else begin : g_rsv
      assign word[b] = 1'b0;
    end
  end

  assign rdata_o = rd_i ? word : '0;
endmodule

// File: rtl/tis_irq_merge.sv
module tis_irq_merge #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(flag_i & en_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/tis_status.sv
module tis_status
  import tis_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              rmw_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  src_vec_t flag_q;
  src_vec_t en_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    tis_flag_cell u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt_i[i]),
      .wr_i   (wr_i),
      .wbit_i (wdata_i[FLAG_LSB+i]),
      .flag_o (flag_q[i])
    );
  end

  tis_enable_reg #(.W(NUM_SRC)) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .wdata_i (wdata_i[EN_LSB +: NUM_SRC]),
    .en_o    (en_q)
  );

  tis_read_mux #(
    .N(NUM_SRC), .DW(DATA_W), .FLAG_LSB(FLAG_LSB), .EN_LSB(EN_LSB)
  ) u_rd (
    .rd_i    (rd_i),
    .rmw_i   (rmw_i),
    .flag_i  (flag_q),
    .en_i    (en_q),
    .rdata_o (rdata_o)
  );

  tis_irq_merge #(.N(NUM_SRC)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flag_i (flag_q),
    .en_i   (en_q),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/tis_status_chk.sv
module tis_status_chk
  import tis_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               wr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic               rd_i,
  input logic               rmw_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] flag_q,
  input logic [NUM_SRC-1:0] en_q
);
  // R3
  evt_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

  // R4
  wr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && evt_i == '0) |=> ((flag_q & ~$past(wdata_i[FLAG_LSB +: NUM_SRC])) == '0));

  // R4
  wr_one_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ((flag_q & wdata_i[FLAG_LSB +: NUM_SRC]) != '0)) |=>
    ((flag_q & $past(flag_q & wdata_i[FLAG_LSB +: NUM_SRC])) == $past(flag_q & wdata_i[FLAG_LSB +: NUM_SRC])));

  // R6
  rmw_flags_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rmw_i) |-> (rdata_o[FLAG_LSB +: NUM_SRC] == '1));

  // R2
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[7] == 1'b0) && (rdata_o[3] == 1'b0));

  // R9
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == '0));

  // R8
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q & en_q) != '0) |=> irq_o);

  // R8
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q & en_q) == '0) |=> !irq_o);
endmodule

bind tis_status tis_status_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .evt_i   (evt_i),
  .wr_i    (wr_i),
  .wdata_i (wdata_i),
  .rd_i    (rd_i),
  .rmw_i   (rmw_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .flag_q  (flag_q),
  .en_q    (en_q)
);

// File: tb/tb_tis_status.sv
`timescale 1ns/1ps
module tb_tis_status;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] evt_i = '0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       rd_i = 1'b0;
  logic       rmw_i = 1'b0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [2:0] m_flag = '0;
  logic [2:0] m_en = '0;

  always #2 clk_i = ~clk_i;

  tis_status dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rd_i(rd_i), .rmw_i(rmw_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%02h exp=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  // one cycle with optional write and events; model updated per requirements
  task automatic cyc(input logic w, input logic [7:0] d, input logic [2:0] e);
    wr_i = w; wdata_i = d; evt_i = e;
    @(posedge clk_i);
    m_flag = e | (w ? (m_flag & d[2:0]) : m_flag);   // R3 R4 R5
    if (w) m_en = d[6:4];                            // R7
    @(negedge clk_i);
    wr_i = 1'b0; wdata_i = '0; evt_i = '0;
  endtask

  task automatic rd_chk(input logic r, input string req);
    rd_i = 1'b1; rmw_i = r;
    #1;
    chk(req, rdata_o, {1'b0, m_en, 1'b0, (r ? 3'b111 : m_flag)});
    rd_i = 1'b0; rmw_i = 1'b0;
    #0.1;
  endtask

  task automatic irq_chk(input string req);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(req, {7'd0, irq_o}, {7'd0, |(m_flag & m_en)});
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    rd_chk(1'b0, "R1 reset read");
    chk("R1 reset irq", {7'd0, irq_o}, 8'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd_chk(1'b0, "R1 post-reset read");

    // R2 R7 reserved bits ignored, enables loaded
    cyc(1'b1, 8'hFF, 3'b000);
    rd_chk(1'b0, "R2 R7 reserved zero / enables");
    cyc(1'b1, 8'h50, 3'b000);
    rd_chk(1'b0, "R7 enable pattern");

    // R3 R4 R5 R6 R8 sweep: stored flags x write flag bits x same-cycle events
    for (int s = 0; s < 8; s++)
      for (int d = 0; d < 8; d++)
        for (int e = 0; e < 8; e++) begin
          logic [2:0] en_v;
          logic [2:0] keep;
          en_v = 3'((s + d + e) % 8);
          cyc(1'b1, 8'h00, 3'b000);
          cyc(1'b0, 8'h00, 3'(s));
          rd_chk(1'b0, "R3 event sets flag");
          cyc(1'b1, {1'b1, en_v, 1'b1, 3'(d)}, 3'(e));
          rd_chk(1'b0, "R4 R5 flag after write+event");
          keep = m_flag;
          rd_chk(1'b1, "R6 rmw read");
          rd_chk(1'b0, "R6 no state change");
          chk("R6 flags kept", {5'd0, keep}, {5'd0, m_flag});
          irq_chk("R8 irq level");
        end

    // R8 enable x flag sweep, and fall after clearing enables
    for (int f = 0; f < 8; f++)
      for (int n = 0; n < 8; n++) begin
        cyc(1'b1, {1'b0, 3'(n), 4'b0000}, 3'(f));
        irq_chk("R8 irq enable sweep");
        cyc(1'b1, 8'h07, 3'b000);
        irq_chk("R8 irq after enable clear");
      end

    // R9 no read strobe
    cyc(1'b1, 8'h70, 3'b111);
    #1;
    chk("R9 idle rdata", rdata_o, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule